// File: doc/BRIEF.md
# Switch-Programmed Waveform Synthesizer

The block is a direct digital synthesis source clocked at 50 MHz. It produces one new 10-bit unsigned sample on every clock for a video-style DAC channel. The operator sets a frequency in hertz as an 18-bit unsigned switch value. An active-low range button scales that value by 256. A second active-low button chooses a sine or a triangle output, and either choice can be changed while the generator runs.

The requested frequency goes through a fixed-point constant multiply to become a 32-bit phase increment, which is registered. A 32-bit phase accumulator adds this increment on every clock. The top phase bits then either address a computed 256-entry sine table or form a symmetric triangle, and the result is registered as the output sample. The DAC's blanking and sync controls are held high, and the sample clock is forwarded to the DAC.

Top module: `dds_synth`

## Requirements
- R1: On every clock edge after reset, the 32-bit phase grows by the current increment, modulo 2^32.
- R2: With the range button released (`range_btn_ni` = 1), the increment is round(sw · 2^32 / 50e6), taken modulo 2^32. For example, sw = 128 gives 10995.
- R3: With the range button pressed (`range_btn_ni` = 0), the effective frequency is sw · 256. For sw = 128 this is 32768 Hz, which gives an increment of 2814750.
- R4: With the wave button released (`wave_btn_ni` = 1), the sample is S[p[31:24]], where p is the phase and S[k] = floor(512 + 511·sin(2πk/256)).
- R5: With the wave button pressed (`wave_btn_ni` = 0), let t = p[31:21]. The sample is t[9:0] when t[10] = 0 and ~t[9:0] when t[10] = 1.
- R6: Each button passes through two flip-flops before use. At each clock edge the increment register loads a value computed from the switches and the synchronised range button. At the same edge the phase register adds the old increment, and the sample register loads from the old phase and the synchronised wave button.
- R7: An asynchronous low on `rst_ni` clears the phase and the increment to 0, sets both buttons to the released state, and sets the sample to 512.
- R8: When the increment is 0 the phase does not move, so the sample stays constant.
- R9: `dac_blank_o` and `dac_sync_o` are always 1, and `dac_clk_o` follows `clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 50 MHz sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_sw_i | input | 18 | Requested frequency in Hz |
| range_btn_ni | input | 1 | Range ×256 button, low when pressed |
| wave_btn_ni | input | 1 | Waveform button, low selects triangle |
| dac_code_o | output | 10 | Unsigned DAC sample |
| dac_blank_o | output | 1 | DAC blanking control, held high |
| dac_sync_o | output | 1 | DAC sync control, held high |
| dac_clk_o | output | 1 | Forwarded sample clock |

## Verification
Any error in the increment or the phase builds up as drift in the sample stream. Once the phase has moved far enough to cross a table step or a triangle code, the output departs from a reference that uses exact rational rounding. This happens within a few samples at high frequencies and within a few hundred at the low ones. A mistake in the table, the triangle fold or the sync depth shows up within one to three cycles of the stimulus that exposes it. The bench therefore compares every sample against the reference across a sweep of switch values in all four button combinations. It also checks that the output holds still when the increment is zero, and that the output returns to mid-scale on reset.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam real PI = 3.14159265358979323846;
  localparam int  SYNC_STAGES = 2;

  typedef enum logic {
    WAVE_SINE = 1'b0,
    WAVE_TRI  = 1'b1
  } wave_e;
endpackage

// File: rtl/dds_btn_sync.sv
module dds_btn_sync
  import dds_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  output logic pressed_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], btn_ni};
  end

  assign pressed_o = ~sync_q[SYNC_STAGES-1];

  // R6
  sync_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pressed_o) |-> !$past(btn_ni, 2));
endmodule

// File: rtl/dds_freq_scale.sv
module dds_freq_scale #(
  parameter int SW_W        = 18,
  parameter int ACC_W       = 32,
  parameter int CLK_HZ      = 50_000_000,
  parameter int RANGE_SHIFT = 8,
  parameter int FRAC_W      = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SW_W-1:0]  freq_i,
  input  logic             range_i,
  output logic [ACC_W-1:0] inc_o
);
  localparam int FEFF_W = SW_W + RANGE_SHIFT;
  localparam int MATH_W = 128;
  // 2^(ACC_W+FRAC_W)/CLK_HZ, rounded; FRAC_W keeps the error below one rounding step
  localparam logic [MATH_W-1:0] SCALE_K =
    ((MATH_W'(1) << (ACC_W + FRAC_W)) + MATH_W'(CLK_HZ / 2)) / MATH_W'(CLK_HZ);
  localparam logic [MATH_W-1:0] HALF_LSB = MATH_W'(1) << (FRAC_W - 1);
  localparam logic [MATH_W-1:0] NORM_MAX =
    ((MATH_W'({SW_W{1'b1}}) * SCALE_K) + HALF_LSB) >> FRAC_W;

  logic [FEFF_W-1:0] f_eff_w;
  logic [MATH_W-1:0] prod_w;
  logic [ACC_W-1:0]  inc_d;

  assign f_eff_w = range_i ? {freq_i, {RANGE_SHIFT{1'b0}}} : FEFF_W'(freq_i);
  assign prod_w  = MATH_W'(f_eff_w) * SCALE_K;
  assign inc_d   = ACC_W'((prod_w + HALF_LSB) >> FRAC_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inc_o <= '0;
    else         inc_o <= inc_d;
  end

  // R8
  zero_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freq_i == '0) |=> (inc_o == '0));

  // R2
  inc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !range_i |=> (MATH_W'(inc_o) <= NORM_MAX));
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32,
  parameter int TOP_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] inc_i,
  output logic [TOP_W-1:0] phase_top_o
);
  logic [ACC_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + inc_i;
  end

  assign phase_top_o = phase_q[ACC_W-1 -: TOP_W];

  // R8
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i == '0) |=> $stable(phase_q));
endmodule

// File: rtl/dds_wave_gen.sv
module dds_wave_gen
  import dds_pkg::*;
#(
  parameter int DAC_W  = 10,
  parameter int LUT_AW = 8,
  parameter int TOP_W  = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TOP_W-1:0] phase_top_i,
  input  wave_e            wave_i,
  output logic [DAC_W-1:0] sample_o
);
  localparam int DEPTH = 1 << LUT_AW;
  localparam int MID   = 1 << (DAC_W - 1);
  localparam int AMP   = MID - 1;

  typedef logic [DAC_W-1:0] code_t;

  function automatic code_t sine_code(int k);
    real a;
    a = real'(MID) + real'(AMP) * $sin(2.0 * PI * real'(k) / real'(DEPTH));
    return code_t'($rtoi(a));
  endfunction

  code_t rom_w [DEPTH];
  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign rom_w[k] = sine_code(k);
  end

  logic [LUT_AW-1:0] addr_w;
  logic [DAC_W:0]    tri_ph_w;
  code_t             tri_w;
  code_t             next_w;

  assign addr_w   = phase_top_i[TOP_W-1 -: LUT_AW];
  assign tri_ph_w = phase_top_i[TOP_W-1 -: DAC_W+1];
  assign tri_w    = tri_ph_w[DAC_W] ? ~tri_ph_w[DAC_W-1:0] : tri_ph_w[DAC_W-1:0];
  assign next_w   = (wave_i == WAVE_TRI) ? tri_w : rom_w[addr_w];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_o <= code_t'(MID);
    else         sample_o <= next_w;
  end

  // R4
  sine_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_i == WAVE_SINE) |=> (sample_o != '0));
endmodule

// File: rtl/dds_synth.sv
module dds_synth
  import dds_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int SW_W        = 18,
  parameter int ACC_W       = 32,
  parameter int RANGE_SHIFT = 8,
  parameter int FRAC_W      = 48,
  parameter int DAC_W       = 10,
  parameter int LUT_AW      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SW_W-1:0]  freq_sw_i,
  input  logic             range_btn_ni,
  input  logic             wave_btn_ni,
  output logic [DAC_W-1:0] dac_code_o,
  output logic             dac_blank_o,
  output logic             dac_sync_o,
  output logic             dac_clk_o
);
  localparam int TOP_W = (LUT_AW > DAC_W + 1) ? LUT_AW : DAC_W + 1;

  logic             range_w;
  logic             tri_w;
  logic [ACC_W-1:0] inc_w;
  logic [TOP_W-1:0] phase_top_w;
  wave_e            wave_w;

  dds_btn_sync u_range_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .btn_ni   (range_btn_ni),
    .pressed_o(range_w)
  );

  dds_btn_sync u_wave_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .btn_ni   (wave_btn_ni),
    .pressed_o(tri_w)
  );

  assign wave_w = tri_w ? WAVE_TRI : WAVE_SINE;

  dds_freq_scale #(
    .SW_W       (SW_W),
    .ACC_W      (ACC_W),
    .CLK_HZ     (CLK_HZ),
    .RANGE_SHIFT(RANGE_SHIFT),
    .FRAC_W     (FRAC_W)
  ) u_scale (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .freq_i (freq_sw_i),
    .range_i(range_w),
    .inc_o  (inc_w)
  );

  dds_phase_acc #(
    .ACC_W(ACC_W),
    .TOP_W(TOP_W)
  ) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_i      (inc_w),
    .phase_top_o(phase_top_w)
  );

  dds_wave_gen #(
    .DAC_W (DAC_W),
    .LUT_AW(LUT_AW),
    .TOP_W (TOP_W)
  ) u_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_top_i(phase_top_w),
    .wave_i     (wave_w),
    .sample_o   (dac_code_o)
  );

  assign dac_blank_o = 1'b1;
  assign dac_sync_o  = 1'b1;
  assign dac_clk_o   = clk_i;
endmodule

// File: tb/dds_synth_tb_top.sv
`timescale 1ns/1ps
module dds_synth_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] sw = '0;
  logic        rng_n = 1'b1;
  logic        wav_n = 1'b1;
  logic [9:0]  dac;
  logic        blank, sync, dclk;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  int          lut [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_synth dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .freq_sw_i   (sw),
    .range_btn_ni(rng_n),
    .wave_btn_ni (wav_n),
    .dac_code_o  (dac),
    .dac_blank_o (blank),
    .dac_sync_o  (sync),
    .dac_clk_o   (dclk)
  );

  initial begin
    for (int k = 0; k < 256; k++)
      lut[k] = $rtoi(512.0 + 511.0 * $sin(2.0 * 3.14159265358979323846 * real'(k) / 256.0));
  end

  // exact rounding of f*2^32/50e6 (no ties: the divisor is odd after reduction)
  function automatic logic [31:0] exp_inc(logic [17:0] s, logic pressed);
    longint unsigned f, num;
    f   = pressed ? (longint'(s) << 8) : longint'(s);
    num = (f << 33) + 64'd50_000_000;
    return 32'(num / 64'd100_000_000);
  endfunction

  function automatic logic [9:0] tri_of(logic [31:0] p);
    logic [10:0] t;
    t = p[31:21];
    return t[10] ? ~t[9:0] : t[9:0];
  endfunction

  // reference built from R1..R7 timing
  logic        m_r1, m_r2, m_w1, m_w2;
  logic [31:0] m_inc, m_ph;
  logic [9:0]  m_out;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 <= 1'b1; m_r2 <= 1'b1; m_w1 <= 1'b1; m_w2 <= 1'b1;
      m_inc <= '0; m_ph <= '0; m_out <= 10'd512;
    end else begin
      m_r1  <= rng_n; m_r2 <= m_r1;
      m_w1  <= wav_n; m_w2 <= m_w1;
      m_inc <= exp_inc(sw, !m_r2);
      m_ph  <= m_ph + m_inc;
      m_out <= !m_w2 ? tri_of(m_ph) : 10'(lut[m_ph[31:24]]);
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic run_stream(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(32'(dac), 32'(m_out), tag);
    end
  endtask

  initial begin
    logic [17:0] vals [8];
    logic [9:0]  held;
    vals = '{18'd128, 18'd1, 18'd3, 18'd1000, 18'd65535, 18'd262143, 18'd195312, 18'd12345};

    // R7 R9: reset state
    repeat (3) @(negedge clk);
    check(32'(dac), 32'd512, "R7 reset sample");
    check(32'(blank), 32'd1, "R9 blank");
    check(32'(sync), 32'd1, "R9 sync");
    check(32'(dclk), 32'd0, "R9 clk low");
    @(posedge clk); #1;
    check(32'(dclk), 32'd1, "R9 clk high");
    @(negedge clk); rst_n = 1'b1;

    // R8: zero frequency after reset stays mid-scale
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(32'(dac), 32'd512, "R8 zero hold");
    end

    // R2 R3 R4 R5 with R1 R6: sweep switch values over all button combinations
    foreach (vals[v]) begin
      for (int r = 0; r < 2; r++) begin
        for (int w = 0; w < 2; w++) begin
          sw = vals[v]; rng_n = (r == 0); wav_n = (w == 0);
          run_stream(260, $sformatf("R1 R6 %s %s sw=%0d",
                     (r != 0) ? "R3" : "R2", (w != 0) ? "R5" : "R4", vals[v]));
        end
      end
    end

    // R3: bit 7 with range, live wave toggling
    sw = 18'd128; rng_n = 1'b0; wav_n = 1'b0;
    run_stream(300, "R3 R5 32768Hz");
    wav_n = 1'b1;
    run_stream(300, "R3 R4 32768Hz");

    // R8: increment forced to zero mid-run
    sw = 18'd0;
    run_stream(3, "R8 settle");
    held = dac;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check(32'(dac), 32'(held), "R8 mid-run hold");
    end

    // R7: asynchronous reset mid-stream
    sw = 18'd50000; rng_n = 1'b0; wav_n = 1'b0;
    run_stream(100, "R5 pre-reset");
    #(CLK_PERIOD/4) rst_n = 1'b0; #1;
    check(32'(dac), 32'd512, "R7 async reset");
    @(negedge clk); rst_n = 1'b1;
    run_stream(200, "R7 R5 restart");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule